// File: doc/BRIEF.md
# Interval Timer Host Register Sequencer

This block is the processor-facing side of a three-channel, 16-bit interval timer. It sits between an 8-bit data bus with a 2-bit address and the three counter cores. Addresses 0, 1 and 2 reach the data port of channels 0, 1 and 2. Address 3 is a control port that accepts writes only. Control words choose a channel's access width and counting mode, freeze a channel's count, or freeze status for several channels at once through a read-back command.

Each channel steps through its own byte sequence for writes and another for reads. When a count is complete, the block sends all 16 bits to the channel's core as a one-cycle load pulse. It also passes each channel's mode to the core and samples each core's live count and output level. A data read picks its byte by a fixed priority. A frozen status byte comes first. A frozen count comes next. The live count is returned only when neither is pending. The counting modes themselves belong to the cores and are outside this block.

Top module: `tmr_host_port`

## Requirements
- R1: A control write whose channel field (bits 7:6) is 0 to 2 and whose access field (bits 5:4) is nonzero stores that access field and the mode in bits 3:1 for the channel. It also returns the channel's read and write byte sequences to their first byte. A control write never produces a load pulse.
- R2: In access mode 1 (low byte only), each data write produces a load pulse on the next cycle with count value {8'h00, byte}.
- R3: In access mode 2 (high byte only), each data write produces a load pulse on the next cycle with count value {byte, 8'h00}.
- R4: In access mode 3 (low then high), the first data write only stores the byte. The second write loads {second byte, first byte} and the sequence goes back to expecting a low byte. At most one channel pulses in any cycle, and only one cycle after a data write to that channel.
- R5: A control write with access field 0 freezes the channel's live count and records the access mode in force. Further freeze commands to that channel are ignored until the frozen count has been fully read.
- R6: A frozen count in mode 3 reads back low byte, then high byte, and then clears. In mode 1 it returns the low byte and in mode 2 the high byte, and a single read clears it.
- R7: A data read returns a pending status byte first and clears it. Otherwise it returns a frozen count. Otherwise it returns the live count.
- R8: A read-back command has 3 in bits 7:6 and selects channels 0, 1 and 2 with bits 1, 2 and 3. If bit 5 is 0, it freezes the count of each selected channel that has no frozen count. If bit 4 is 0, it freezes status for each selected channel that has no status pending.
- R9: The status byte is {output level, 0, access mode[1:0], channel mode[2:0], 0}, captured when the command executes.
- R10: With no status or frozen count pending, live reads in mode 1 give the low byte and in mode 2 the high byte. In mode 3 they alternate, starting with the low byte.
- R11: A read at address 3 returns 8'hFF and changes no state.
- R12: After reset every channel is in access mode 3 and mode 0, has no status or frozen count pending, and no load pulse is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Address: 0-2 channel data, 3 control |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; side effects on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| live_cnt | input | NUM_CH*16 | Live count of each core, channel 0 in the low bits |
| ch_out | input | NUM_CH | Output level of each core |
| ld_valid | output | NUM_CH | One-cycle load pulse per channel |
| ld_value | output | NUM_CH*16 | Count carried with each load pulse |
| ch_mode | output | NUM_CH*3 | Programmed mode per channel |

## Verification
The bench targets the following corner cases, and each one shows up as a specific wrong byte or wrong pulse:
- Freeze commands repeated while a frozen count is still unread. A design that re-captures would return a newer live value instead of the first snapshot.
- A read that lands after a status freeze and a count freeze together. If the priority is wrong, the count byte appears before the status byte.
- A word-mode write or read interrupted by a fresh control word. A design that does not reset the sequences would load a mixed count, or return the high byte first.
- A read-back that names some channels but not others. A wrong mask bit would freeze a channel that was not asked for.
- Reads at the control address placed between the two bytes of a frozen word. These must leave the word intact.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = 2 * BYTE_W;
  localparam int MODE_W    = 3;
  localparam int ADDR_W    = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd3;
  localparam logic [BYTE_W-1:0] CTRL_READ_VAL = 8'hFF;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  // Count value delivered to the core for a completing write.
  function automatic logic [CNT_W-1:0] load_value(input acc_e acc,
                                                  input logic [BYTE_W-1:0] held,
                                                  input logic [BYTE_W-1:0] d);
    case (acc)
      ACC_LO:   load_value = {{BYTE_W{1'b0}}, d};
      ACC_HI:   load_value = {d, {BYTE_W{1'b0}}};
      ACC_WORD: load_value = {d, held};
      default:  load_value = '0;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v,
                                                  input logic hi);
    pick_byte = hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic out_lvl,
                                                    input acc_e acc,
                                                    input logic [MODE_W-1:0] mode);
    status_byte = {out_lvl, 1'b0, acc, mode, 1'b0};
  endfunction
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] cw,
  output logic [NUM_CH-1:0] setup_p,
  output logic [NUM_CH-1:0] latch_cnt_p,
  output logic [NUM_CH-1:0] latch_st_p,
  output acc_e              acc_f,
  output logic [MODE_W-1:0] mode_f
);
  logic [1:0] sel_f;
  logic       is_rb;
  logic       rb_no_cnt;
  logic       rb_no_st;
  logic       cw_unused;

  assign sel_f     = cw[7:6];
  assign acc_f     = acc_e'(cw[5:4]);
  assign mode_f    = cw[3:1];
  assign is_rb     = (sel_f == 2'd3);
  assign rb_no_cnt = cw[5];
  assign rb_no_st  = cw[4];
  assign cw_unused = cw[0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    logic hit;
    assign hit = !is_rb && (sel_f == 2'(i));
    assign setup_p[i]     = ctrl_wr && hit && (acc_f != ACC_LATCH);
    assign latch_cnt_p[i] = ctrl_wr && (is_rb ? (cw[i+1] && !rb_no_cnt)
                                              : (hit && acc_f == ACC_LATCH));
    assign latch_st_p[i]  = ctrl_wr && is_rb && cw[i+1] && !rb_no_st;
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_p,
  input  acc_e              acc_in,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              latch_cnt_p,
  input  logic              latch_st_p,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              out_lvl,
  output logic [BYTE_W-1:0] rbyte,
  output logic              ld_valid,
  output logic [CNT_W-1:0]  ld_value,
  output logic [MODE_W-1:0] mode_o,
  output logic              st_pend,
  output logic [1:0]        cnt_pend,
  output logic [CNT_W-1:0]  lat_val
);
  acc_e              acc_q;
  logic [MODE_W-1:0] mode_q;
  logic              wr_hi;
  logic              rd_hi;
  logic [BYTE_W-1:0] wlat;
  logic [BYTE_W-1:0] st_val;
  acc_e              cnt_pend_q;
  logic              load_now;

  assign mode_o   = mode_q;
  assign cnt_pend = cnt_pend_q;
  assign load_now = data_wr && ((acc_q != ACC_WORD) || wr_hi);

  always_comb begin
    if (st_pend)
      rbyte = st_val;
    else if (cnt_pend_q != ACC_LATCH)
      rbyte = pick_byte(lat_val, cnt_pend_q == ACC_HI);
    else
      rbyte = pick_byte(live_cnt, (acc_q == ACC_HI) || (acc_q == ACC_WORD && rd_hi));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= ACC_WORD;
      mode_q     <= '0;
      wr_hi      <= 1'b0;
      rd_hi      <= 1'b0;
      wlat       <= '0;
      st_val     <= '0;
      st_pend    <= 1'b0;
      cnt_pend_q <= ACC_LATCH;
      lat_val    <= '0;
      ld_valid   <= 1'b0;
      ld_value   <= '0;
    end else begin
      ld_valid <= load_now;
      if (load_now)
        ld_value <= load_value(acc_q, wlat, wdata);

      if (setup_p) begin
        acc_q  <= acc_in;
        mode_q <= mode_in;
        wr_hi  <= 1'b0;
        rd_hi  <= 1'b0;
      end

      if (data_wr && acc_q == ACC_WORD) begin
        if (!wr_hi) wlat <= wdata;
        wr_hi <= !wr_hi;
      end

      if (latch_cnt_p && cnt_pend_q == ACC_LATCH) begin
        lat_val    <= live_cnt;
        cnt_pend_q <= acc_q;
      end

      if (latch_st_p && !st_pend) begin
        st_val  <= status_byte(out_lvl, acc_q, mode_q);
        st_pend <= 1'b1;
      end

      if (data_rd) begin
        if (st_pend)
          st_pend <= 1'b0;
        else if (cnt_pend_q == ACC_WORD)
          cnt_pend_q <= ACC_HI;
        else if (cnt_pend_q != ACC_LATCH)
          cnt_pend_q <= ACC_LATCH;
        else if (acc_q == ACC_WORD)
          rd_hi <= !rd_hi;
      end
    end
  end
endmodule

// File: rtl/tmr_host_port.sv
module tmr_host_port
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_sel,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [BYTE_W-1:0]       bus_wdata,
  output logic [BYTE_W-1:0]       bus_rdata,
  input  logic [NUM_CH*CNT_W-1:0] live_cnt,
  input  logic [NUM_CH-1:0]       ch_out,
  output logic [NUM_CH-1:0]       ld_valid,
  output logic [NUM_CH*CNT_W-1:0] ld_value,
  output logic [NUM_CH*MODE_W-1:0] ch_mode
);
  logic              ctrl_wr;
  logic [NUM_CH-1:0] setup_p, latch_cnt_p, latch_st_p;
  acc_e              acc_f;
  logic [MODE_W-1:0] mode_f;

  // Named internal events, visible to the bound checker.
  logic [NUM_CH-1:0]       st_pend_w;
  logic [NUM_CH*2-1:0]     cnt_pend_w;
  logic [NUM_CH*CNT_W-1:0] lat_hold_w;
  logic [BYTE_W-1:0]       rbyte_a [NUM_CH];

  assign ctrl_wr = bus_wr && (bus_sel == CTRL_ADDR);

  tmr_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .ctrl_wr    (ctrl_wr),
    .cw         (bus_wdata),
    .setup_p    (setup_p),
    .latch_cnt_p(latch_cnt_p),
    .latch_st_p (latch_st_p),
    .acc_f      (acc_f),
    .mode_f     (mode_f)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = (bus_sel == ADDR_W'(i));
    tmr_chan_port u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .setup_p    (setup_p[i]),
      .acc_in     (acc_f),
      .mode_in    (mode_f),
      .latch_cnt_p(latch_cnt_p[i]),
      .latch_st_p (latch_st_p[i]),
      .data_wr    (bus_wr && hit),
      .data_rd    (bus_rd && !bus_wr && hit),
      .wdata      (bus_wdata),
      .live_cnt   (live_cnt[i*CNT_W +: CNT_W]),
      .out_lvl    (ch_out[i]),
      .rbyte      (rbyte_a[i]),
      .ld_valid   (ld_valid[i]),
      .ld_value   (ld_value[i*CNT_W +: CNT_W]),
      .mode_o     (ch_mode[i*MODE_W +: MODE_W]),
      .st_pend    (st_pend_w[i]),
      .cnt_pend   (cnt_pend_w[i*2 +: 2]),
      .lat_val    (lat_hold_w[i*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    bus_rdata = CTRL_READ_VAL;
    for (int i = 0; i < NUM_CH; i++)
      if (bus_sel == ADDR_W'(i)) bus_rdata = rbyte_a[i];
  end
endmodule

// File: rtl/tmr_host_port_chk.sv
module tmr_host_port_chk
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       bus_sel,
  input logic                    bus_wr,
  input logic                    bus_rd,
  input logic [BYTE_W-1:0]       bus_rdata,
  input logic [NUM_CH-1:0]       ld_valid,
  input logic [NUM_CH-1:0]       st_pend_w,
  input logic [NUM_CH*2-1:0]     cnt_pend_w,
  input logic [NUM_CH*CNT_W-1:0] lat_hold_w
);
  a_r4_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_valid));

  a_r11_ctrl_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == CTRL_ADDR) |-> (bus_rdata == CTRL_READ_VAL));

  a_r12_no_load_in_reset: assert property (@(posedge clk)
    !rst_n |=> (ld_valid == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r4_load_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid[i] |-> $past(bus_wr && bus_sel == ADDR_W'(i)));

    a_r7_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_sel == ADDR_W'(i) && st_pend_w[i]) |=> !st_pend_w[i]);

    a_r5_frozen_held: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_pend_w[i*2 +: 2] != 2'd0 && !(bus_rd && !bus_wr && bus_sel == ADDR_W'(i)))
      |=> ($stable(lat_hold_w[i*CNT_W +: CNT_W]) && cnt_pend_w[i*2 +: 2] != 2'd0));
  end
endmodule

bind tmr_host_port tmr_host_port_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .ld_valid  (ld_valid),
  .st_pend_w (st_pend_w),
  .cnt_pend_w(cnt_pend_w),
  .lat_hold_w(lat_hold_w)
);

// File: tb/tmr_host_port_tb.sv
module tmr_host_port_tb;
  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic [47:0] live_cnt = 48'd0;
  logic [2:0]  ch_out = 3'd0;
  logic [2:0]  ld_valid;
  logic [47:0] ld_value;
  logic [8:0]  ch_mode;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Bench reference state per channel.
  int         m_acc [NC];
  int         m_mode [NC];
  bit         m_wrhi [NC];
  bit         m_rdhi [NC];
  logic [7:0] m_wlat [NC];
  int         m_clp [NC];
  logic [15:0] m_clv [NC];
  bit         m_stp [NC];
  logic [7:0] m_stv [NC];

  always #2.5 clk = ~clk;

  tmr_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .live_cnt(live_cnt), .ch_out(ch_out),
    .ld_valid(ld_valid), .ld_value(ld_value), .ch_mode(ch_mode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] live_of(input int c);
    return live_cnt[c*16 +: 16];
  endfunction

  task automatic model_freeze(input int c);
    if (m_clp[c] == 0) begin
      m_clv[c] = live_of(c);
      m_clp[c] = m_acc[c];
    end
  endtask

  task automatic model_status(input int c);
    if (!m_stp[c]) begin
      m_stp[c] = 1;
      m_stv[c] = {ch_out[c], 1'b0, 2'(m_acc[c]), 3'(m_mode[c]), 1'b0};
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    logic [2:0]  exp_v;
    logic [15:0] exp_val;
    string       tag;
    exp_v = 3'd0;
    exp_val = 16'd0;
    tag = "R1";
    if (a == 2'd3) begin
      if (d[7:6] == 2'd3) begin
        for (int c = 0; c < NC; c++)
          if (d[c+1]) begin
            if (!d[5]) model_freeze(c);
            if (!d[4]) model_status(c);
          end
      end else if (d[5:4] == 2'd0) begin
        model_freeze(int'(d[7:6]));
      end else begin
        m_acc[d[7:6]]  = int'(d[5:4]);
        m_mode[d[7:6]] = int'(d[3:1]);
        m_wrhi[d[7:6]] = 0;
        m_rdhi[d[7:6]] = 0;
      end
    end else begin
      case (m_acc[a])
        1: begin exp_v[a] = 1'b1; exp_val = {8'h00, d}; tag = "R2"; end
        2: begin exp_v[a] = 1'b1; exp_val = {d, 8'h00}; tag = "R3"; end
        default: begin
          tag = "R4";
          if (!m_wrhi[a]) begin m_wlat[a] = d; m_wrhi[a] = 1; end
          else begin exp_v[a] = 1'b1; exp_val = {d, m_wlat[a]}; m_wrhi[a] = 0; end
        end
      endcase
    end
    @(negedge clk);
    bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    check({tag, " load pulse"}, 32'(ld_valid), 32'(exp_v));
    if (exp_v != 3'd0) check({tag, " load value"}, 32'(ld_value[a*16 +: 16]), 32'(exp_val));
  endtask

  task automatic bus_read(input logic [1:0] a);
    logic [7:0] exp;
    string      tag;
    if (a == 2'd3) begin
      exp = 8'hFF; tag = "R11";
    end else if (m_stp[a]) begin
      exp = m_stv[a]; m_stp[a] = 0; tag = "R9/R7 status";
    end else if (m_clp[a] != 0) begin
      tag = "R6/R5 frozen";
      if (m_clp[a] == 2) begin exp = m_clv[a][15:8]; m_clp[a] = 0; end
      else if (m_clp[a] == 1) begin exp = m_clv[a][7:0]; m_clp[a] = 0; end
      else begin exp = m_clv[a][7:0]; m_clp[a] = 2; end
    end else begin
      tag = "R10 live";
      if (m_acc[a] == 2) exp = live_of(a)[15:8];
      else if (m_acc[a] == 1) exp = live_of(a)[7:0];
      else begin
        exp = m_rdhi[a] ? live_of(a)[15:8] : live_of(a)[7:0];
        m_rdhi[a] = !m_rdhi[a];
      end
    end
    @(negedge clk);
    bus_sel = a; bus_rd = 1'b1;
    #1;
    check(tag, 32'(bus_rdata), 32'(exp));
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic shake_inputs();
    @(negedge clk);
    live_cnt = {$urandom, $urandom};
    ch_out = 3'($urandom);
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'h5EED);
    for (int c = 0; c < NC; c++) begin
      m_acc[c] = 3; m_mode[c] = 0; m_wrhi[c] = 0; m_rdhi[c] = 0; m_wlat[c] = 0;
      m_clp[c] = 0; m_clv[c] = 0; m_stp[c] = 0; m_stv[c] = 0;
    end
    live_cnt = 48'h3344_2211_BEEF;
    ch_out = 3'b101;
    repeat (4) @(posedge clk);
    #1;
    check("R12 reset load idle", 32'(ld_valid), 32'd0);
    check("R12 reset mode", 32'(ch_mode), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R12 / R9: read-back status and count of channel 0 right after reset
    bus_write(2'd3, 8'hC2);
    bus_read(2'd0);           // status first (R7)
    bus_read(2'd0);           // frozen low
    bus_read(2'd3);           // R11: no side effect between bytes
    bus_read(2'd0);           // frozen high
    bus_read(2'd0);           // live low (R10)
    bus_read(2'd0);           // live high

    // R1/R2: channel 1 low-only, mode 2
    bus_write(2'd3, 8'h54);
    bus_write(2'd1, 8'hA5);
    // R3: channel 2 high-only
    bus_write(2'd3, 8'hA6);
    bus_write(2'd2, 8'h3C);
    // R4: channel 0 word, then sequence reset by a new control word
    bus_write(2'd3, 8'h30);
    bus_write(2'd0, 8'h11);
    bus_write(2'd3, 8'h36);
    bus_write(2'd0, 8'h22);
    bus_write(2'd0, 8'h33);
    // R5: second freeze ignored while unread
    bus_write(2'd3, 8'h00);
    live_cnt[15:0] = 16'h9999;
    bus_write(2'd3, 8'h00);
    bus_read(2'd0);
    bus_read(2'd0);
    // R8: read-back of channels 1 and 2 only, status and count
    bus_write(2'd3, 8'hCC);
    bus_read(2'd0);
    bus_read(2'd1);
    bus_read(2'd1);
    bus_read(2'd2);
    bus_read(2'd2);
    // R8: status-only read-back of channel 2 (bit 5 set)
    bus_write(2'd3, 8'hE8);
    bus_read(2'd2);
    bus_read(2'd2);

    for (int n = 0; n < 1500; n++) begin
      int op;
      op = int'($urandom % 8);
      if (($urandom % 4) == 0) shake_inputs();
      case (op)
        0: bus_write(2'd3, {2'($urandom % 3), 2'(1 + $urandom % 3), 3'($urandom), 1'b0});
        1: bus_write(2'd3, {2'($urandom % 3), 2'b00, 4'($urandom)});
        2: bus_write(2'd3, {2'b11, 2'($urandom), 3'($urandom), 1'b0});
        3, 4: bus_write(2'($urandom % 3), 8'($urandom));
        default: bus_read(2'($urandom));
      endcase
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule